// File: doc/BRIEF.md
# Audio Co-processor Address Decoder and Register Block

This block sits between the byte-wide CPU port of an audio co-processor and everything that port can reach in a 16-bit address space. Each access is steered, from its address alone, to one of four targets: a small group of I/O registers near the bottom of the map, an indirect window into the signal-processor register file, the working RAM, or a read-only table in the top 64 bytes. Reads are combinational, so data belongs to the address presented in the same cycle. Writes land on the rising clock edge.

The signal-processor register file is not mapped directly. Software first loads an 8-bit index into the index latch at 0x00F2, then reads or writes the selected entry through the data port at 0x00F3. The file holds 8 voices of 10 byte registers each, plus 15 global byte registers. The index is folded into range, so every index value reaches a real entry. The test register (0x00F0) and the control register (0x00F1) are plain byte registers.

The RAM is cleared by a hardware sweep after reset. A two-state machine controls the sweep. It starts in SWEEP when reset is released. It takes the transition SWEEP->READY when the last word has been cleared, and it stays in READY until the next reset. The array spans 2^RAM_AW bytes: 65536 in the full configuration and 4096 by default, with higher address bits folded away.

Top module: `audbus_top`

## Requirements
- R1: After reset, the test, control and index registers, and every register-file entry reached through 0x00F3, read 0x00. Every RAM address reads 0x00.
- R2: `ram_ready` is low for exactly 2^RAM_AW clock edges after reset is released, then stays high. While it is low, RAM reads return 0x00 and RAM writes are dropped.
- R3: Addresses 0x00F0 (test) and 0x00F1 (control) are separate byte registers that read back what was last written, and writes to them leave RAM unchanged.
- R4: Address 0x00F2 reads and writes the 8-bit index latch.
- R5: Address 0x00F3 reads and writes the register-file entry chosen by the index. Index bit 7 = 1 selects global register (bits 6:0 mod 15). Index bit 7 = 0 selects voice (bits 6:4) register (bits 3:0 mod 10).
- R6: A voice register field of 10..15 aliases to register 0..5 of the same voice.
- R7: A global field of 15 or more aliases to that field mod 15 (for example, 20 reaches 5 and 127 reaches 7).
- R8: Any address below 0xFFC0, other than 0x00F0..0x00F3, reads and writes the RAM byte at address mod 2^RAM_AW.
- R9: Addresses 0xFFC0..0xFFFF read 0xFF, and writes there change no RAM byte or register.
- R10: A write becomes visible only after the clock edge. During the write cycle, the read data shows the old content of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Byte address of the current access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| ram_ready | output | 1 | High once the RAM clear sweep is complete |

## Verification
A wrong decode or wrong index folding shows up on the first read of the affected address, one cycle after the write that should have landed there. Because each write is followed by a read of an independent address, an aliasing fault appears as soon as two addresses collide in the bench's model. A fault in the sweep state machine shows as an early or late `ram_ready`, or as a nonzero read taken before the sweep completes. An unchecked write during the sweep shows as data that survives the sweep. All of these are visible within the first few thousand cycles.

// File: rtl/audbus_pkg.sv
package audbus_pkg;

    localparam logic [15:0] ADDR_TEST  = 16'h00F0;
    localparam logic [15:0] ADDR_CTRL  = 16'h00F1;
    localparam logic [15:0] ADDR_INDEX = 16'h00F2;
    localparam logic [15:0] ADDR_DATA  = 16'h00F3;
    localparam logic [15:0] ROM_BASE   = 16'hFFC0;
    localparam logic [7:0]  ROM_FILL   = 8'hFF;

    typedef enum logic [2:0] {
        RG_RAM,
        RG_ROM,
        RG_TEST,
        RG_CTRL,
        RG_INDEX,
        RG_DATA
    } region_e;

    typedef enum logic [0:0] {
        ST_SWEEP,
        ST_READY
    } clr_state_e;

endpackage

// File: rtl/audbus_decode.sv
module audbus_decode
    import audbus_pkg::*;
(
    input  logic [15:0] addr,
    output region_e     region
);
    always_comb begin
        if (addr >= ROM_BASE)         region = RG_ROM;
        else if (addr == ADDR_TEST)   region = RG_TEST;
        else if (addr == ADDR_CTRL)   region = RG_CTRL;
        else if (addr == ADDR_INDEX)  region = RG_INDEX;
        else if (addr == ADDR_DATA)   region = RG_DATA;
        else                          region = RG_RAM;
    end
endmodule

// File: rtl/audbus_regfile.sv
module audbus_regfile #(
    parameter int VOICES = 8,
    parameter int VREGS  = 10,
    parameter int GREGS  = 15,
    parameter int IDX_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             dat_wr,
    input  logic [7:0]       wdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [7:0]       dat_rdata
);
    localparam int VSEL_W = $clog2(VOICES);
    localparam int RSEL_W = $clog2(VREGS);
    localparam int GSEL_W = $clog2(GREGS);

    logic [7:0] voice_q [VOICES][VREGS];
    logic [7:0] glob_q  [GREGS];

    logic              is_glob;
    logic [VSEL_W-1:0] v_sel;
    logic [RSEL_W-1:0] r_sel;
    logic [GSEL_W-1:0] g_sel;

    // Fold every index field into range of its table.
    always_comb begin
        is_glob   = idx_q[IDX_W-1];
        r_sel     = RSEL_W'(int'(idx_q[RSEL_W-1:0]) % VREGS);
        v_sel     = VSEL_W'(int'(idx_q[RSEL_W +: VSEL_W]) % VOICES);
        g_sel     = GSEL_W'(int'(idx_q[IDX_W-2:0]) % GREGS);
        dat_rdata = is_glob ? glob_q[g_sel] : voice_q[v_sel][r_sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_wr) begin
            idx_q <= IDX_W'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < VOICES; v++)
                for (int r = 0; r < VREGS; r++)
                    voice_q[v][r] <= '0;
            for (int g = 0; g < GREGS; g++)
                glob_q[g] <= '0;
        end else if (dat_wr) begin
            if (is_glob) glob_q[g_sel] <= wdata;
            else         voice_q[v_sel][r_sel] <= wdata;
        end
    end
endmodule

// File: rtl/audbus_ram.sv
module audbus_ram
    import audbus_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output logic          ready
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] ptr_q;
    clr_state_e    state_q, state_d;
    logic          sweep_we;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SWEEP;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        sweep_we = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_SWEEP: begin
                sweep_we = 1'b1;
                if (ptr_q == {AW{1'b1}}) state_d = ST_READY;
            end
            ST_READY: begin
                ready = 1'b1;
            end
            default: state_d = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr_q <= '0;
        else if (sweep_we) ptr_q <= ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (sweep_we)        mem[ptr_q] <= '0;
        else if (wr && ready) mem[addr]  <= wdata;
    end

    assign rdata = ready ? mem[addr] : 8'h00;
endmodule

// File: rtl/audbus_top.sv
module audbus_top
    import audbus_pkg::*;
#(
    parameter int RAM_AW = 12,
    parameter int VOICES = 8,
    parameter int VREGS  = 10,
    parameter int GREGS  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        ram_ready
);
    localparam int IDX_W = 8;

    region_e          region;
    logic [7:0]       test_q, ctrl_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       reg_rdata, ram_rdata;

    audbus_decode u_dec (
        .addr   (bus_addr),
        .region (region)
    );

    audbus_regfile #(
        .VOICES (VOICES),
        .VREGS  (VREGS),
        .GREGS  (GREGS),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (bus_wr && region == RG_INDEX),
        .dat_wr    (bus_wr && region == RG_DATA),
        .wdata     (bus_wdata),
        .idx_q     (idx_q),
        .dat_rdata (reg_rdata)
    );

    audbus_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr[RAM_AW-1:0]),
        .wr    (bus_wr && region == RG_RAM),
        .wdata (bus_wdata),
        .rdata (ram_rdata),
        .ready (ram_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            test_q <= '0;
            ctrl_q <= '0;
        end else if (bus_wr) begin
            if (region == RG_TEST) test_q <= bus_wdata;
            if (region == RG_CTRL) ctrl_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (region)
            RG_TEST:  bus_rdata = test_q;
            RG_CTRL:  bus_rdata = ctrl_q;
            RG_INDEX: bus_rdata = 8'(idx_q);
            RG_DATA:  bus_rdata = reg_rdata;
            RG_ROM:   bus_rdata = ROM_FILL;
            default:  bus_rdata = ram_rdata;
        endcase
    end
endmodule

// File: rtl/audbus_chk.sv
module audbus_chk
    import audbus_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic        ram_ready
);
    // R9
    rom_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr >= ROM_BASE |-> bus_rdata == ROM_FILL);

    // R2
    sweep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ready && bus_addr < ROM_BASE && (bus_addr < ADDR_TEST || bus_addr > ADDR_DATA))
        |-> bus_rdata == 8'h00);

    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ready |=> ram_ready);

    // R4
    index_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_INDEX)
        |=> (bus_addr != ADDR_INDEX || bus_rdata == $past(bus_wdata)));

    // R3
    test_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_TEST)
        |=> (bus_addr != ADDR_TEST || bus_rdata == $past(bus_wdata)));

    // R3
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && bus_addr == ADDR_CTRL)
        |=> (bus_addr != ADDR_CTRL || bus_rdata == $past(bus_rdata)));
endmodule

bind audbus_top audbus_chk u_chk (.*);

// File: tb/sim_audbus_top.sv
module sim_audbus_top;
    localparam int RAM_AW = 12;
    localparam int DEPTH  = 1 << RAM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ram_ready;

    int tests = 0, fails = 0;
    int cyc = 0;
    bit done = 0;

    logic [7:0] ram_m [DEPTH];
    logic [7:0] voice_m [8][10];
    logic [7:0] glob_m [15];
    logic [7:0] test_m, ctrl_m, idx_m;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    audbus_top #(.RAM_AW(RAM_AW)) u0 (.*);

    function automatic bit is_ram(logic [15:0] a);
        return a < 16'hFFC0 && (a < 16'h00F0 || a > 16'h00F3);
    endfunction

    function automatic logic [7:0] file_rd(logic [7:0] ix);
        if (ix[7]) return glob_m[int'(ix[6:0]) % 15];
        return voice_m[ix[6:4]][int'(ix[3:0]) % 10];
    endfunction

    function automatic logic [7:0] exp_rd(logic [15:0] a);
        if (a >= 16'hFFC0) return 8'hFF;
        case (a)
            16'h00F0: return test_m;
            16'h00F1: return ctrl_m;
            16'h00F2: return idx_m;
            16'h00F3: return file_rd(idx_m);
            default:  return ram_m[a[RAM_AW-1:0]];
        endcase
    endfunction

    function automatic string tag_of(logic [15:0] a);
        if (a >= 16'hFFC0) return "R9";
        case (a)
            16'h00F0, 16'h00F1: return "R3";
            16'h00F2: return "R4";
            16'h00F3: return "R5";
            default:  return "R8";
        endcase
    endfunction

    task automatic model_wr(logic [15:0] a, logic [7:0] d);
        if (a >= 16'hFFC0) return;
        case (a)
            16'h00F0: test_m = d;
            16'h00F1: ctrl_m = d;
            16'h00F2: idx_m = d;
            16'h00F3: begin
                if (idx_m[7]) glob_m[int'(idx_m[6:0]) % 15] = d;
                else voice_m[idx_m[6:4]][int'(idx_m[3:0]) % 10] = d;
            end
            default: if (ram_ready) ram_m[a[RAM_AW-1:0]] = d;
        endcase
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(logic [15:0] a, string tag);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 check(tag, bus_rdata, exp_rd(a));
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int c0;
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) ram_m[i] = 8'h00;
        for (int v = 0; v < 8; v++) for (int r = 0; r < 10; r++) voice_m[v][r] = 8'h00;
        for (int g = 0; g < 15; g++) glob_m[g] = 8'h00;
        test_m = 0; ctrl_m = 0; idx_m = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c0 = cyc;

        // R1: reset state of registers and RAM
        rd(16'h00F0, "R1"); rd(16'h00F1, "R1"); rd(16'h00F2, "R1");
        rd(16'h00F3, "R1"); rd(16'h0010, "R1");
        // R2: writes during sweep are dropped, reads give zero
        wr(16'h0123, 8'h5A);
        rd(16'h0123, "R2");
        while (!ram_ready) @(negedge clk);
        check("R2", 8'(cyc - c0 - DEPTH), 8'h00);
        if (cyc - c0 != DEPTH) $display("FAIL R2: got %0d expected %0d edges", cyc - c0, DEPTH);
        rd(16'h0123, "R2");
        rd(16'h0FFF, "R1");

        // R10: during the write cycle the old value is seen
        @(negedge clk);
        bus_addr = 16'h0200; bus_wr = 1'b1; bus_wdata = 8'hC3;
        #1 check("R10", bus_rdata, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0; model_wr(16'h0200, 8'hC3);
        #1 check("R10", bus_rdata, 8'hC3);

        // R3: test and control separate, no RAM effect
        wr(16'h00F0, 8'h11); wr(16'h00F1, 8'h22);
        rd(16'h00F0, "R3"); rd(16'h00F1, "R3");
        rd(16'h00F0 | 16'h1000, "R3");
        // R6: voice 3, register field 12 aliases register 2
        wr(16'h00F2, 8'h3C); wr(16'h00F3, 8'hA5);
        wr(16'h00F2, 8'h32); rd(16'h00F3, "R6");
        check("R6", bus_rdata, 8'hA5);
        // R7: global fields 20 -> 5 and 127 -> 7
        wr(16'h00F2, 8'h94); wr(16'h00F3, 8'h66);
        wr(16'h00F2, 8'h85); rd(16'h00F3, "R7");
        check("R7", bus_rdata, 8'h66);
        wr(16'h00F2, 8'hFF); wr(16'h00F3, 8'h77);
        wr(16'h00F2, 8'h87); rd(16'h00F3, "R7");
        check("R7", bus_rdata, 8'h77);
        // R8: address folding
        wr(16'h1234, 8'h9E); rd(16'h0234, "R8");
        check("R8", bus_rdata, 8'h9E);
        // R9: top area reads FF and ignores writes
        wr(16'hFFC5, 8'h12); rd(16'hFFC5, "R9"); rd(16'h0FC5, "R9");
        rd(16'hFFBF, "R8");

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            int k = int'($urandom % 8);
            case (k)
                0, 1: a = 16'h00F0 + 16'($urandom % 4);
                2:    a = 16'hFFC0 + 16'($urandom % 64);
                3:    a = ($urandom % 2) ? 16'hFFBF : 16'hFFC0;
                4:    a = 16'h00F2;
                default: a = 16'($urandom);
            endcase
            wr(a, 8'($urandom));
            a = ($urandom % 2) ? a : (($urandom % 2) ? 16'h00F3 : 16'($urandom));
            rd(a, tag_of(a));
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule